// File: doc/BRIEF.md
# MSI Interrupt File Controller

This block is the interrupt file that one hart uses for message-signalled interrupts. Devices ring a 32-bit doorbell carrying an interrupt identity number. The doorbell can be written in little-endian form, or in big-endian form, in which case its bytes are reversed before use. Each valid doorbell sets one pending bit. Software reaches the file through an indirect register port. A select index picks the register, and every access is a masked read-modify-write that returns the old contents. A read is an access with a zero mask, and a full write is an access with an all-ones mask.

The file holds the following state:
- a delivery-enable flag;
- a priority threshold;
- for each group of 64 identities, one pending word and one enable word.

The arbiter picks the smallest identity that is both pending and enabled and that passes the threshold. It reports that identity through a top-identity register. A write to the top-identity register claims the identity, which clears its pending bit. The external interrupt output is registered, and it follows the next-state contents of the file.

Select encoding:

| Select | Register | Notes |
|---|---|---|
| 0x070 | Delivery enable | |
| 0x072 | Threshold | |
| 0x080 + 2g | Pending word of group g | |
| 0x0C0 + 2g | Enable word of group g | |
| 0x100 | Top identity | |

Response status codes: 0 = ok, 1 = invalid index, 2 = unknown select.

Top module: `msif_file`

## Requirements
- R1: After reset the following are all zero, and `ext_irq` is low: delivery enable, threshold, every pending word, every enable word, and the top identity.
- R2: An access with select, value V and mask M sets the register to (old & ~M) | (V & M). The old value is returned on `rsp_rdata` in the cycle after the request, with `rsp_valid` high.
- R3: Bit 0 of the group-0 pending word and bit 0 of the group-0 enable word always read 0. A doorbell carrying identity 0 is ignored. Identity i maps to group i/64, bit i mod 64.
- R4: Among the identities that are pending and enabled, the lowest-numbered one is reported.
- R5: Threshold cutoff:
  - When the threshold T is nonzero and T ≤ NUM_IDS, only identities below T are eligible.
  - Otherwise every implemented identity is eligible.
- R6: The top-identity register reads (id << 16) | id. It reads 0 when no identity is eligible.
- R7: An access to the top-identity register with a nonzero mask clears the pending bit of the identity it reported. The written value is ignored. A zero mask clears nothing, and when nothing is eligible the access changes nothing.
- R8: `ext_irq` is high exactly when delivery bit 0 is set and an identity is eligible. It is registered, so it reflects a change made at a clock edge right after that edge.
- R9: Only bit 0 of the delivery register is writable. Only the low log2(ID_LIMIT) bits of the threshold are writable.
- R10: Select errors:
  - A pending or enable select with an odd offset, or with a group at or beyond the implemented count, returns status 1.
  - Any select not listed in the encoding table returns status 2.
  - An erroring access returns data 0 and changes no state.
- R11: Doorbell decoding:
  - When `db_swap` is low, `db_data` is used as it is.
  - When `db_swap` is high, the four bytes of `db_data` are reversed before use.
  - A value of 0, or a value at or above NUM_IDS, is ignored.
- R12: A doorbell and a claim of the same identity in the same cycle leave that identity pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_req | input | 1 | Register access request |
| reg_sel | input | 9 | Register select index |
| reg_wdata | input | 64 | Value to merge |
| reg_wmask | input | 64 | Bits to replace |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_rdata | output | 64 | Old register value |
| rsp_status | output | 2 | 0 ok, 1 invalid index, 2 unknown select |
| db_valid | input | 1 | Doorbell write strobe |
| db_swap | input | 1 | Doorbell arrived at the big-endian offset |
| db_data | input | 32 | Doorbell payload |
| ext_irq | output | 1 | External interrupt request |

## Verification
The arbiter is driven with several pending sets:
- Two pending identities in different groups, so that picking the highest identity or the wrong word would show up.
- A pair of identities combined with thresholds just below, at and just above the lower identity, and at, just above and far above NUM_IDS. These separate an off-by-one cutoff from a wrong range check on the threshold.

Doorbells are sent as a byte-reversed payload, and as an unswapped copy of that same payload. The result tells a missing swap apart from a swap applied at both offsets. The last pattern rings a doorbell and claims in the same cycle, once for the same identity and once for a different one. This shows whether the pending bit set by the doorbell wins over the claim.

// File: rtl/msif_pkg.sv
package msif_pkg;
    localparam int SEL_W = 9;
    localparam logic [SEL_W-1:0] SEL_DELIV     = 9'h070;
    localparam logic [SEL_W-1:0] SEL_THRESH    = 9'h072;
    localparam logic [SEL_W-1:0] SEL_PEND_BASE = 9'h080;
    localparam logic [SEL_W-1:0] SEL_EN_BASE   = 9'h0C0;
    localparam logic [SEL_W-1:0] SEL_TOP       = 9'h100;
    localparam int TOP_SHIFT = 16;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_INVAL   = 2'd1,
        ST_UNKNOWN = 2'd2
    } msif_status_e;

    typedef enum logic [2:0] {
        K_NONE, K_DELIV, K_THR, K_PEND, K_EN, K_TOP
    } msif_kind_e;

    function automatic logic [63:0] masked_merge(input logic [63:0] old_v,
                                                 input logic [63:0] new_v,
                                                 input logic [63:0] mask);
        return (old_v & ~mask) | (new_v & mask);
    endfunction
endpackage

// File: rtl/msif_sel_decode.sv
module msif_sel_decode
    import msif_pkg::*;
#(
    parameter int NUM_GROUPS = 2,
    parameter int GW = 1
) (
    input  logic [SEL_W-1:0] sel,
    output msif_kind_e       kind,
    output logic [GW-1:0]    grp,
    output msif_status_e     status
);
    logic [5:0] off;

    always_comb begin
        kind   = K_NONE;
        grp    = '0;
        status = ST_OK;
        off    = '0;
        if (sel == SEL_DELIV) begin
            kind = K_DELIV;
        end else if (sel == SEL_THRESH) begin
            kind = K_THR;
        end else if (sel == SEL_TOP) begin
            kind = K_TOP;
        end else if (sel >= SEL_PEND_BASE && sel < SEL_EN_BASE) begin
            kind = K_PEND;
            off  = 6'(sel - SEL_PEND_BASE);
        end else if (sel >= SEL_EN_BASE && sel < SEL_EN_BASE + 9'd64) begin
            kind = K_EN;
            off  = 6'(sel - SEL_EN_BASE);
        end else begin
            status = ST_UNKNOWN;
        end
        if (kind == K_PEND || kind == K_EN) begin
            if (off[0] || (32'(off[5:1]) >= 32'(NUM_GROUPS))) begin
                status = ST_INVAL;
                kind   = K_NONE;
            end else begin
                grp = GW'(off[5:1]);
            end
        end
    end
endmodule

// File: rtl/msif_prio.sv
module msif_prio #(
    parameter int NUM_IDS = 128,
    parameter int TW = 11,
    parameter int IDW = 7
) (
    input  logic [NUM_IDS-1:0] cand,
    input  logic [TW-1:0]      thr,
    output logic [IDW-1:0]     id,
    output logic               found
);
    logic lim_on;

    always_comb begin
        lim_on = (thr != '0) && (32'(thr) <= 32'(NUM_IDS));
        id     = '0;
        found  = 1'b0;
        for (int i = NUM_IDS - 1; i >= 1; i--) begin
            if (cand[i] && (!lim_on || (32'(i) < 32'(thr)))) begin
                id    = IDW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/msif_doorbell.sv
module msif_doorbell #(
    parameter int NUM_IDS = 128,
    parameter int IDW = 7
) (
    input  logic           valid,
    input  logic           swap,
    input  logic [31:0]    data,
    output logic           hit,
    output logic [IDW-1:0] id
);
    logic [31:0] val;

    always_comb begin
        val = swap ? {data[7:0], data[15:8], data[23:16], data[31:24]} : data;
        hit = valid && (val != 32'd0) && (val < 32'(NUM_IDS));
        id  = IDW'(val);
    end
endmodule

// File: rtl/msif_file.sv
module msif_file
    import msif_pkg::*;
#(
    parameter int NUM_IDS  = 128,
    parameter int ID_LIMIT = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_req,
    input  logic [8:0]        reg_sel,
    input  logic [63:0]       reg_wdata,
    input  logic [63:0]       reg_wmask,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    output logic [1:0]        rsp_status,
    input  logic              db_valid,
    input  logic              db_swap,
    input  logic [31:0]       db_data,
    output logic              ext_irq
);
    localparam int NUM_GROUPS = (NUM_IDS + 63) / 64;
    localparam int TW  = $clog2(ID_LIMIT);
    localparam int IDW = $clog2(NUM_IDS);
    localparam int GW  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
    localparam int FLAT = NUM_GROUPS * 64;

    typedef struct packed {
        logic                         deliv;
        logic [TW-1:0]                thr;
        logic [NUM_GROUPS-1:0][63:0]  eip;
        logic [NUM_GROUPS-1:0][63:0]  eie;
        logic                         rsp_valid;
        logic [63:0]                  rsp_rdata;
        logic [1:0]                   rsp_status;
    } msif_state_t;

    msif_state_t st_d, st_q;
    logic        irq_d, irq_q;

    msif_kind_e   kind;
    logic [GW-1:0] grp;
    msif_status_e dec_status;

    msif_sel_decode #(.NUM_GROUPS(NUM_GROUPS), .GW(GW)) u_dec (
        .sel(reg_sel), .kind(kind), .grp(grp), .status(dec_status)
    );

    logic           db_hit;
    logic [IDW-1:0] db_id;

    msif_doorbell #(.NUM_IDS(NUM_IDS), .IDW(IDW)) u_db (
        .valid(db_valid), .swap(db_swap), .data(db_data), .hit(db_hit), .id(db_id)
    );

    logic [FLAT-1:0]  cand_all_q, cand_all_d;
    logic [IDW-1:0]   top_id_q, top_id_d;
    logic             top_found_q, top_found_d;
    logic [63:0]      top_val_q;

    assign cand_all_q = st_q.eip & st_q.eie;
    assign cand_all_d = st_d.eip & st_d.eie;

    msif_prio #(.NUM_IDS(NUM_IDS), .TW(TW), .IDW(IDW)) u_prio_cur (
        .cand(cand_all_q[NUM_IDS-1:0]), .thr(st_q.thr), .id(top_id_q), .found(top_found_q)
    );

    msif_prio #(.NUM_IDS(NUM_IDS), .TW(TW), .IDW(IDW)) u_prio_next (
        .cand(cand_all_d[NUM_IDS-1:0]), .thr(st_d.thr), .id(top_id_d), .found(top_found_d)
    );

    assign top_val_q = (64'(top_id_q) << TOP_SHIFT) | 64'(top_id_q);

    logic [31:0] claim_g, claim_b, db_g, db_b;
    logic [63:0] word_mask;

    always_comb begin
        st_d            = st_q;
        st_d.rsp_valid  = reg_req;
        st_d.rsp_rdata  = '0;
        st_d.rsp_status = ST_OK;
        claim_g   = 32'(top_id_q) >> 6;
        claim_b   = 32'(top_id_q) & 32'd63;
        db_g      = 32'(db_id) >> 6;
        db_b      = 32'(db_id) & 32'd63;
        word_mask = reg_wmask & ~((grp == '0) ? 64'd1 : 64'd0);
        if (reg_req) begin
            st_d.rsp_status = dec_status;
            case (kind)
                K_DELIV: begin
                    st_d.rsp_rdata = {63'd0, st_q.deliv};
                    st_d.deliv = (st_q.deliv & ~reg_wmask[0]) | (reg_wdata[0] & reg_wmask[0]);
                end
                K_THR: begin
                    st_d.rsp_rdata = 64'(st_q.thr);
                    st_d.thr = (st_q.thr & ~reg_wmask[TW-1:0]) | (reg_wdata[TW-1:0] & reg_wmask[TW-1:0]);
                end
                K_PEND: begin
                    st_d.rsp_rdata = st_q.eip[grp];
                    st_d.eip[grp]  = masked_merge(st_q.eip[grp], reg_wdata, word_mask);
                end
                K_EN: begin
                    st_d.rsp_rdata = st_q.eie[grp];
                    st_d.eie[grp]  = masked_merge(st_q.eie[grp], reg_wdata, word_mask);
                end
                K_TOP: begin
                    st_d.rsp_rdata = top_val_q;
                    if ((reg_wmask != '0) && top_found_q)
                        st_d.eip[claim_g[GW-1:0]][claim_b[5:0]] = 1'b0;
                end
                default: ;
            endcase
        end
        // doorbell applied last so a same-cycle claim cannot drop it
        if (db_hit)
            st_d.eip[db_g[GW-1:0]][db_b[5:0]] = 1'b1;
        st_d.eip[0][0] = 1'b0;
        st_d.eie[0][0] = 1'b0;
    end

    assign irq_d = st_d.deliv && top_found_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= '0;
            irq_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            irq_q <= irq_d;
        end
    end

    assign rsp_valid  = st_q.rsp_valid;
    assign rsp_rdata  = st_q.rsp_rdata;
    assign rsp_status = st_q.rsp_status;
    assign ext_irq    = irq_q;

    AST_NONZERO_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        top_found_q |-> (top_id_q != '0)); // R3
    AST_WINNER_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        top_found_q |-> cand_all_q[top_id_q]); // R4
    AST_BELOW_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (top_found_q && (st_q.thr != '0) && (32'(st_q.thr) <= 32'(NUM_IDS)))
            |-> (32'(top_id_q) < 32'(st_q.thr))); // R5
    AST_IRQ_NEEDS_DELIVERY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> st_q.deliv); // R8
    AST_IRQ_MATCHES_FILE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q == (st_q.deliv && top_found_q)); // R8
    AST_ERROR_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rsp_valid && (st_q.rsp_status != ST_OK))
            |-> (st_q.eie == $past(st_q.eie) && st_q.thr == $past(st_q.thr)
                 && st_q.deliv == $past(st_q.deliv))); // R10
endmodule

// File: tb/tb_msif_file.sv
`timescale 1ns/1ps
module tb_msif_file;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req = 1'b0;
    logic [8:0]  reg_sel = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_wmask = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic [1:0]  rsp_status;
    logic        db_valid = 1'b0;
    logic        db_swap = 1'b0;
    logic [31:0] db_data = '0;
    logic        ext_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [8:0] S_DEL = 9'h070, S_THR = 9'h072, S_P0 = 9'h080, S_P1 = 9'h082,
                           S_E0 = 9'h0C0, S_E1 = 9'h0C2, S_TOP = 9'h100;
    localparam logic [63:0] ONES = '1;

    always #2.5 clk = ~clk;

    msif_file dut (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_wmask(reg_wmask), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_status(rsp_status), .db_valid(db_valid),
        .db_swap(db_swap), .db_data(db_data), .ext_irq(ext_irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic [8:0] sel, input logic [63:0] v, input logic [63:0] m,
                       output logic [63:0] rd, output logic [1:0] st);
        @(negedge clk);
        reg_req = 1'b1; reg_sel = sel; reg_wdata = v; reg_wmask = m;
        @(negedge clk);
        reg_req = 1'b0;
        rd = rsp_rdata;
        st = rsp_status;
        if (rsp_valid !== 1'b1) chk("R2 rsp_valid", {63'd0, rsp_valid}, 64'd1);
    endtask

    task automatic rd_chk(input string tag, input logic [8:0] sel, input logic [63:0] exp);
        logic [63:0] rd; logic [1:0] st;
        acc(sel, 64'd0, 64'd0, rd, st);
        chk(tag, rd, exp);
    endtask

    task automatic wr(input logic [8:0] sel, input logic [63:0] v);
        logic [63:0] rd; logic [1:0] st;
        acc(sel, v, ONES, rd, st);
    endtask

    task automatic ring(input logic swap, input logic [31:0] d);
        @(negedge clk);
        db_valid = 1'b1; db_swap = swap; db_data = d;
        @(negedge clk);
        db_valid = 1'b0;
    endtask

    function automatic logic [63:0] topv(input int id);
        return (64'(id) << 16) | 64'(id);
    endfunction

    task automatic t_reset();
        chk("R1 irq", {63'd0, ext_irq}, 64'd0);
        rd_chk("R1 deliv", S_DEL, 64'd0);
        rd_chk("R1 thr", S_THR, 64'd0);
        rd_chk("R1 pend0", S_P0, 64'd0);
        rd_chk("R1 en1", S_E1, 64'd0);
        rd_chk("R1 top", S_TOP, 64'd0);
    endtask

    task automatic t_rmw();
        logic [63:0] rd; logic [1:0] st;
        acc(S_E0, 64'hFFFF_0000_0000_00F0, ONES, rd, st);
        chk("R2 old zero", rd, 64'd0);
        acc(S_E0, 64'd0, 64'h30, rd, st);
        chk("R2 old returned", rd, 64'hFFFF_0000_0000_00F0);
        rd_chk("R2 merged", S_E0, 64'hFFFF_0000_0000_00C0);
        acc(S_P1, 64'hA, 64'h3, rd, st);
        rd_chk("R2 partial mask", S_P1, 64'h2);
        wr(S_E0, 64'd0);
        wr(S_P1, 64'd0);
    endtask

    task automatic t_bit0();
        wr(S_E0, ONES);
        rd_chk("R3 enable bit0", S_E0, 64'hFFFF_FFFF_FFFF_FFFE);
        wr(S_P0, ONES);
        rd_chk("R3 pending bit0", S_P0, 64'hFFFF_FFFF_FFFF_FFFE);
        wr(S_P0, 64'd0);
        wr(S_E0, 64'd0);
        ring(1'b0, 32'd0);
        ring(1'b1, 32'd0);
        rd_chk("R3 doorbell zero ignored", S_P0, 64'd0);
    endtask

    task automatic t_widths();
        wr(S_DEL, ONES);
        rd_chk("R9 deliv one bit", S_DEL, 64'd1);
        wr(S_THR, ONES);
        rd_chk("R9 thr width", S_THR, 64'h7FF);
        wr(S_THR, 64'd0);
        wr(S_DEL, 64'd0);
    endtask

    task automatic t_prio();
        logic [63:0] rd; logic [1:0] st;
        wr(S_E0, ONES);
        wr(S_E1, ONES);
        ring(1'b0, 32'd70);
        ring(1'b0, 32'd5);
        rd_chk("R4 lowest wins", S_TOP, topv(5));
        chk("R8 no delivery no irq", {63'd0, ext_irq}, 64'd0);
        wr(S_DEL, 64'd1);
        chk("R8 irq asserted", {63'd0, ext_irq}, 64'd1);
        rd_chk("R7 zero mask keeps", S_TOP, topv(5));
        acc(S_TOP, 64'd0, 64'd1, rd, st);
        chk("R6 claim returns format", rd, topv(5));
        rd_chk("R7 next after claim", S_TOP, topv(70));
        rd_chk("R3 id70 group1 bit6", S_P1, 64'd1 << 6);
        acc(S_TOP, ONES, ONES, rd, st);
        chk("R7 claim 70", rd, topv(70));
        rd_chk("R6 empty top", S_TOP, 64'd0);
        chk("R8 irq drops", {63'd0, ext_irq}, 64'd0);
        acc(S_TOP, 64'd0, ONES, rd, st);
        chk("R7 empty claim data", rd, 64'd0);
        chk("R7 empty claim status", 64'(st), 64'd0);
        rd_chk("R7 empty claim no change", S_P0, 64'd0);
        wr(S_DEL, 64'd0);
    endtask

    task automatic t_thresh();
        logic [63:0] rd; logic [1:0] st;
        ring(1'b0, 32'd10);
        ring(1'b0, 32'd100);
        wr(S_THR, 64'd50);
        rd_chk("R5 thr 50", S_TOP, topv(10));
        wr(S_THR, 64'd10);
        rd_chk("R5 thr equal id excluded", S_TOP, 64'd0);
        wr(S_THR, 64'd11);
        rd_chk("R5 thr 11", S_TOP, topv(10));
        wr(S_THR, 64'd128);
        acc(S_TOP, 64'd0, ONES, rd, st);
        chk("R5 thr at count", rd, topv(10));
        wr(S_THR, 64'd100);
        rd_chk("R5 thr 100 excludes 100", S_TOP, 64'd0);
        wr(S_THR, 64'd128);
        rd_chk("R5 thr 128", S_TOP, topv(100));
        wr(S_THR, 64'd129);
        rd_chk("R5 thr above count", S_TOP, topv(100));
        wr(S_THR, 64'd2000);
        rd_chk("R5 thr far above", S_TOP, topv(100));
        wr(S_THR, 64'd0);
        rd_chk("R5 thr zero", S_TOP, topv(100));
        acc(S_TOP, 64'd0, ONES, rd, st);
        rd_chk("R7 all claimed", S_TOP, 64'd0);
    endtask

    task automatic t_doorbell();
        ring(1'b1, 32'h2A00_0000);
        rd_chk("R11 swapped id 42", S_P0, 64'd1 << 42);
        ring(1'b0, 32'h2A00_0000);
        ring(1'b1, 32'h0000_002A);
        rd_chk("R11 large ignored p1", S_P1, 64'd0);
        ring(1'b0, 32'd128);
        rd_chk("R11 count ignored", S_P1, 64'd0);
        ring(1'b0, 32'd127);
        rd_chk("R11 last id", S_P1, 64'd1 << 63);
        rd_chk("R11 p0 unchanged", S_P0, 64'd1 << 42);
        wr(S_P0, 64'd0);
        wr(S_P1, 64'd0);
    endtask

    task automatic t_errors();
        logic [63:0] rd; logic [1:0] st;
        acc(9'h081, 64'd0, 64'd0, rd, st);
        chk("R10 odd status", 64'(st), 64'd1);
        chk("R10 odd data", rd, 64'd0);
        acc(9'h0C3, 64'd0, ONES, rd, st);
        chk("R10 odd write status", 64'(st), 64'd1);
        rd_chk("R10 en1 untouched", S_E1, ONES);
        acc(9'h084, 64'd0, 64'd0, rd, st);
        chk("R10 group beyond", 64'(st), 64'd1);
        acc(9'h050, 64'd0, ONES, rd, st);
        chk("R10 unknown", 64'(st), 64'd2);
        acc(9'h101, 64'd0, 64'd0, rd, st);
        chk("R10 unknown above top", 64'(st), 64'd2);
    endtask

    task automatic t_race();
        ring(1'b0, 32'd9);
        wr(S_DEL, 64'd1);
        rd_chk("R12 before", S_TOP, topv(9));
        @(negedge clk);
        reg_req = 1'b1; reg_sel = S_TOP; reg_wdata = '0; reg_wmask = ONES;
        db_valid = 1'b1; db_swap = 1'b0; db_data = 32'd9;
        @(negedge clk);
        reg_req = 1'b0; db_valid = 1'b0;
        chk("R12 claim data", rsp_rdata, topv(9));
        chk("R12 irq held", {63'd0, ext_irq}, 64'd1);
        rd_chk("R12 still pending", S_TOP, topv(9));
        @(negedge clk);
        reg_req = 1'b1; reg_sel = S_TOP; reg_wmask = ONES;
        db_valid = 1'b1; db_data = 32'd20;
        @(negedge clk);
        reg_req = 1'b0; db_valid = 1'b0;
        rd_chk("R12 other id claimed", S_TOP, topv(20));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rmw();
        t_bit0();
        t_widths();
        t_prio();
        t_thresh();
        t_doorbell();
        t_errors();
        t_race();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule